// File: doc/BRIEF.md
# Trigger Source Selection and Gating

This block sits in front of a waveform-digitizer readout engine and turns several candidate trigger sources into one qualified, single-cycle trigger pulse. Four sources feed it: a software force pulse, an external asynchronous line with selectable polarity, a master-trigger line from a link decoder, and an internal programmable-rate generator built as a phase accumulator. A mode bit picks the master-trigger line in place of the external line and the generator. The force pulse is always taken.

Every candidate passes through three gates. The first is a global enable. The second is a holdoff window of a programmable length that opens when a start pulse arrives. The third is the readout busy flag. A candidate that passes the first two gates is counted as an event. If the readout is busy it is also counted as lost and is not forwarded. The block also measures how many cycles the last busy period lasted.

Top module: `trig_gate`

## Requirements
- R1: A one-cycle `force_i` pulse yields exactly one trigger, whether `mst_sel_i` is 0 or 1.
- R2: The external line goes through a two-flop synchronizer. The polarity is then corrected: `ext_act_hi_i`=1 means active-high and 0 means active-low. After that, a rising edge is detected, so a long active level gives a single trigger. `trig_o` rises three clock edges after the line changes. The line has no effect while `ext_en_i`=0.
- R3: With `mst_sel_i`=1 the master line is the only source besides force, and the external line and the generator are ignored. With `mst_sel_i`=0 the master line is ignored. With `mst_level_i`=0 each cycle in which `mst_trig_i` is high is a trigger. With `mst_level_i`=1 only a rising edge is a trigger.
- R4: While `glob_en_i`=0 no trigger is produced and neither counter moves.
- R5: A candidate in the cycle where `start_i` is high is ignored. So is a candidate in any of the following `holdoff_len_i` cycles. The next cycle is accepted.
- R6: The generator adds `gen_rate_i` to a 32-bit accumulator every cycle and fires once per overflow. A rate of 0 never fires, 2^31 fires every second cycle, and 2^30 fires every fourth cycle.
- R7: A candidate seen while `busy_i`=1 does not reach `trig_o`. It increments the 16-bit `lost_cnt_o` and the event counter.
- R8: `evt_cnt_o` (32 bits) increments by exactly one for each cycle holding a candidate that passes the enable and holdoff gates, even when several sources fire in that cycle.
- R9: When `busy_i` falls, `dead_o` takes the number of cycles it was high, one cycle after the fall.
- R10: The deadtime measurement saturates at 0xFFFF.
- R11: `trig_o` is registered and rises one cycle after a qualifying candidate is sampled. After reset, `trig_o` and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, opens the holdoff window |
| holdoff_len_i | input | 8 | Holdoff length in cycles |
| glob_en_i | input | 1 | Global trigger enable |
| force_i | input | 1 | Software force-trigger pulse |
| ext_trig_i | input | 1 | Asynchronous external trigger line |
| ext_en_i | input | 1 | External trigger enable |
| ext_act_hi_i | input | 1 | 1 = external line active-high, 0 = active-low |
| mst_trig_i | input | 1 | Master-trigger line (synchronous) |
| mst_sel_i | input | 1 | 1 = master line replaces external and generator |
| mst_level_i | input | 1 | 1 = master line edge-detected, 0 = taken per cycle |
| gen_rate_i | input | 32 | Internal generator rate word |
| busy_i | input | 1 | Readout busy |
| trig_o | output | 1 | Qualified trigger pulse |
| evt_cnt_o | output | 32 | Triggers received |
| lost_cnt_o | output | 16 | Triggers lost to busy |
| dead_o | output | 16 | Length of the last busy period in cycles |

## Verification
A generator overflow and a force pulse can fall in the same cycle. They must merge into one trigger and one count. The bench provokes this by running the generator at half the clock rate while holding force high across a 64-cycle window. It then expects 64 triggers and an event-counter step of 64, not 96. A candidate can also land in a busy cycle. The bench judges that case by `trig_o` staying low while both counters step by one, and by the measured deadtime once busy falls.

// File: rtl/trig_gate_pkg.sv
// Shared definitions for the trigger gating block.
// Assumes: source indices are dense from zero.
package trig_gate_pkg;
    localparam int SRC_N = 4;

    typedef enum int {
        SRC_FORCE = 0,
        SRC_EXT   = 1,
        SRC_MST   = 2,
        SRC_GEN   = 3
    } trig_src_e;
endpackage

// File: rtl/trig_ext_sync.sv
// External trigger conditioning: multi-flop synchronizer, polarity
// correction, rising-edge detection of the corrected level.
// Assumes: STAGES >= 2; the polarity bit is quasi-static.
module trig_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic act_hi_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              lvl;
    logic              lvl_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], raw_i};
    end

    // Active level after polarity correction.
    always_comb lvl = act_hi_i ? sync_q[STAGES-1] : ~sync_q[STAGES-1];

    // Remember the corrected level; reset high so no edge follows reset.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl;
    end

    // Rising edge of the corrected level.
    always_comb edge_o = lvl & ~lvl_q;
endmodule

// File: rtl/trig_rate_gen.sv
// Internal trigger generator: a phase accumulator adds the rate word
// every cycle and emits a registered one-cycle pulse on each overflow.
// Assumes: the rate word may change at any time; rate 0 never fires.
module trig_rate_gen #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] rate_i,
    output logic             pulse_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    // Accumulator sum with carry out.
    always_comb sum = {1'b0, acc_q} + {1'b0, rate_i};

    // Advance the phase and register the overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            pulse_o <= 1'b0;
        end else begin
            acc_q   <= sum[ACC_W-1:0];
            pulse_o <= sum[ACC_W];
        end
    end
endmodule

// File: rtl/trig_dead_meter.sv
// Deadtime meter: counts cycles while busy is high, saturating at the
// counter maximum, and latches the count when busy falls.
// Assumes: busy is synchronous to clk.
module trig_dead_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    output logic [CNT_W-1:0] dead_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic             busy_q;
    logic [CNT_W-1:0] run_q;

    // Delay busy by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_i;
    end

    // Running length of the current busy period, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                    run_q <= '0;
        else if (busy_i && !busy_q)    run_q <= ONE;
        else if (busy_i && run_q != MAXV) run_q <= run_q + ONE;
    end

    // Latch the period length when busy falls.
    always_ff @(posedge clk) begin
        if (!rst_n)                 dead_o <= '0;
        else if (!busy_i && busy_q) dead_o <= run_q;
    end
endmodule

// File: rtl/trig_gate.sv
// Trigger source selection and gating. Merges force, external, master
// and generated triggers; applies global enable, post-start holdoff and
// busy blocking; counts accepted and lost triggers; measures deadtime.
// Assumes: all inputs except ext_trig_i are synchronous to clk.
module trig_gate
    import trig_gate_pkg::*;
#(
    parameter int HOLD_W      = 8,
    parameter int RATE_W      = 32,
    parameter int EVT_W       = 32,
    parameter int LOST_W      = 16,
    parameter int DEAD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [HOLD_W-1:0] holdoff_len_i,
    input  logic              glob_en_i,
    input  logic              force_i,
    input  logic              ext_trig_i,
    input  logic              ext_en_i,
    input  logic              ext_act_hi_i,
    input  logic              mst_trig_i,
    input  logic              mst_sel_i,
    input  logic              mst_level_i,
    input  logic [RATE_W-1:0] gen_rate_i,
    input  logic              busy_i,
    output logic              trig_o,
    output logic [EVT_W-1:0]  evt_cnt_o,
    output logic [LOST_W-1:0] lost_cnt_o,
    output logic [DEAD_W-1:0] dead_o
);
    logic              ext_edge;
    logic              gen_pulse;
    logic              mst_q;
    logic              mst_cand;
    logic [SRC_N-1:0]  src_vec;
    logic [HOLD_W-1:0] hold_q;
    logic              hold_blk;
    logic              cand;

    trig_ext_sync #(.STAGES(SYNC_STAGES)) ext_sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (ext_trig_i),
        .act_hi_i (ext_act_hi_i),
        .edge_o   (ext_edge)
    );

    trig_rate_gen #(.ACC_W(RATE_W)) rate_gen_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_i  (gen_rate_i),
        .pulse_o (gen_pulse)
    );

    trig_dead_meter #(.CNT_W(DEAD_W)) dead_meter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy_i),
        .dead_o (dead_o)
    );

    // Previous master line value for edge mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mst_q <= 1'b0;
        else        mst_q <= mst_trig_i;
    end

    // Master candidate: per-cycle level or rising edge.
    always_comb mst_cand = mst_level_i ? (mst_trig_i & ~mst_q) : mst_trig_i;

    // Per-source candidates after source selection.
    always_comb begin
        src_vec            = '0;
        src_vec[SRC_FORCE] = force_i;
        src_vec[SRC_EXT]   = ext_en_i & ext_edge & ~mst_sel_i;
        src_vec[SRC_MST]   = mst_cand & mst_sel_i;
        src_vec[SRC_GEN]   = gen_pulse & ~mst_sel_i;
    end

    // Holdoff counter, loaded by start and counted down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            hold_q <= '0;
        else if (start_i)      hold_q <= holdoff_len_i;
        else if (hold_q != '0) hold_q <= hold_q - 1'b1;
    end

    // Candidate that passes enable and holdoff.
    always_comb begin
        hold_blk = start_i | (hold_q != '0);
        cand     = (|src_vec) & glob_en_i & ~hold_blk;
    end

    // Forward the trigger unless busy; count events and losses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_o     <= 1'b0;
            evt_cnt_o  <= '0;
            lost_cnt_o <= '0;
        end else begin
            trig_o     <= cand & ~busy_i;
            evt_cnt_o  <= evt_cnt_o + {{(EVT_W-1){1'b0}}, cand};
            lost_cnt_o <= lost_cnt_o + {{(LOST_W-1){1'b0}}, cand & busy_i};
        end
    end
endmodule

// File: rtl/trig_gate_chk.sv
// Checker for trig_gate: port-level temporal properties, bound below.
module trig_gate_chk #(
    parameter int EVT_W  = 32,
    parameter int LOST_W = 16,
    parameter int DEAD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              glob_en_i,
    input logic              busy_i,
    input logic              trig_o,
    input logic [EVT_W-1:0]  evt_cnt_o,
    input logic [LOST_W-1:0] lost_cnt_o,
    input logic [DEAD_W-1:0] dead_o
);
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !trig_o); // R7

    AST_LOST_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_cnt_o != $past(lost_cnt_o)) |-> $past(busy_i)); // R7

    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en_i |=> (!trig_o && $stable(evt_cnt_o) && $stable(lost_cnt_o))); // R4

    AST_START_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !trig_o); // R5

    AST_TRIG_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> ((evt_cnt_o - $past(evt_cnt_o)) == EVT_W'(1))); // R8

    AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_cnt_o - $past(evt_cnt_o)) == EVT_W'(0)) ||
        ((evt_cnt_o - $past(evt_cnt_o)) == EVT_W'(1))); // R8

    AST_DEAD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_o != $past(dead_o)) |-> ($past(busy_i, 2) && !$past(busy_i))); // R9
endmodule

bind trig_gate trig_gate_chk #(
    .EVT_W  (EVT_W),
    .LOST_W (LOST_W),
    .DEAD_W (DEAD_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .glob_en_i  (glob_en_i),
    .busy_i     (busy_i),
    .trig_o     (trig_o),
    .evt_cnt_o  (evt_cnt_o),
    .lost_cnt_o (lost_cnt_o),
    .dead_o     (dead_o)
);

// File: tb/trig_gate_tb_top.sv
// Scoreboard bench for trig_gate: drivers queue expected trigger cycles,
// a monitor pops and compares them as trig_o fires.
module trig_gate_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i, glob_en_i, force_i, ext_trig_i, ext_en_i, ext_act_hi_i;
    logic        mst_trig_i, mst_sel_i, mst_level_i, busy_i;
    logic [7:0]  holdoff_len_i;
    logic [31:0] gen_rate_i;
    logic        trig_o;
    logic [31:0] evt_cnt_o;
    logic [15:0] lost_cnt_o;
    logic [15:0] dead_o;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   exp_q[$];
    bit   sb_on = 1'b0;
    bit   finished = 1'b0;
    logic [31:0] exp_evt = '0;
    logic [15:0] exp_lost = '0;

    trig_gate dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .holdoff_len_i(holdoff_len_i),
        .glob_en_i(glob_en_i), .force_i(force_i), .ext_trig_i(ext_trig_i),
        .ext_en_i(ext_en_i), .ext_act_hi_i(ext_act_hi_i), .mst_trig_i(mst_trig_i),
        .mst_sel_i(mst_sel_i), .mst_level_i(mst_level_i), .gen_rate_i(gen_rate_i),
        .busy_i(busy_i), .trig_o(trig_o), .evt_cnt_o(evt_cnt_o),
        .lost_cnt_o(lost_cnt_o), .dead_o(dead_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare each trigger against the head of the queue.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && sb_on) begin
            if (trig_o) begin
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    chk("R11", "trigger cycle", 64'(cyc), 64'(exp_q.pop_front()));
                end else begin
                    chk("R11", "unexpected trigger cycle", 64'(cyc), 64'(-1));
                end
            end
            if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                chk("R11", "missing trigger cycle", 64'(-1), 64'(exp_q.pop_front()));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic force_pulse(input bit expect_t);
        @(negedge clk);
        force_i = 1'b1;
        if (expect_t) begin
            exp_q.push_back(cyc + 1);
            exp_evt++;
        end
        @(negedge clk);
        force_i = 1'b0;
    endtask

    task automatic ext_set(input logic val, input bit expect_t);
        @(negedge clk);
        ext_trig_i = val;
        if (expect_t) begin
            exp_q.push_back(cyc + 3);
            exp_evt++;
        end
    endtask

    task automatic window(input int n, output int trigs, output logic [31:0] d);
        logic [31:0] e0;
        e0 = evt_cnt_o;
        trigs = 0;
        repeat (n) begin
            @(negedge clk);
            if (trig_o) trigs++;
        end
        d = evt_cnt_o - e0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        int k;
        int n;
        logic [31:0] d;
        rst_n = 1'b0; start_i = 1'b0; glob_en_i = 1'b0; force_i = 1'b0;
        ext_trig_i = 1'b0; ext_en_i = 1'b0; ext_act_hi_i = 1'b1;
        mst_trig_i = 1'b0; mst_sel_i = 1'b0; mst_level_i = 1'b0; busy_i = 1'b0;
        holdoff_len_i = 8'd0; gen_rate_i = 32'd0;
        tick(3);
        rst_n = 1'b1;
        sb_on = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "trig after reset", 64'(trig_o), 64'(0));
        chk("R11", "evt after reset", 64'(evt_cnt_o), 64'(0));
        chk("R11", "lost after reset", 64'(lost_cnt_o), 64'(0));
        chk("R11", "dead after reset", 64'(dead_o), 64'(0));

        // R4: disabled, force and external edge ignored
        force_pulse(1'b0);
        ext_en_i = 1'b1;
        ext_set(1'b1, 1'b0); tick(5);
        ext_set(1'b0, 1'b0); tick(4);
        chk("R4", "evt while disabled", 64'(evt_cnt_o), 64'(exp_evt));

        // R1: force works with either source selection
        glob_en_i = 1'b1;
        mst_sel_i = 1'b1;
        force_pulse(1'b1);
        mst_sel_i = 1'b0;
        force_pulse(1'b1);
        tick(2);
        chk("R1", "evt after force", 64'(evt_cnt_o), 64'(exp_evt));

        // R2: enable gating, active-high edge, long level gives one trigger
        ext_en_i = 1'b0;
        ext_set(1'b1, 1'b0); tick(6);
        ext_set(1'b0, 1'b0); tick(4);
        ext_en_i = 1'b1;
        ext_set(1'b1, 1'b1); tick(20);
        ext_set(1'b0, 1'b0); tick(5);
        chk("R2", "evt active-high", 64'(evt_cnt_o), 64'(exp_evt));
        // R2: active-low
        ext_en_i = 1'b0;
        ext_act_hi_i = 1'b0;
        ext_set(1'b1, 1'b0); tick(5);
        ext_en_i = 1'b1; tick(2);
        ext_set(1'b0, 1'b1); tick(10);
        ext_set(1'b1, 1'b0); tick(5);
        ext_en_i = 1'b0;
        ext_act_hi_i = 1'b1; tick(3);
        ext_set(1'b0, 1'b0); tick(4);
        ext_en_i = 1'b1;
        chk("R2", "evt active-low", 64'(evt_cnt_o), 64'(exp_evt));

        // R3: master selected, external ignored; pulse then edge mode
        mst_sel_i = 1'b1;
        ext_set(1'b1, 1'b0); tick(6);
        ext_set(1'b0, 1'b0); tick(4);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            mst_trig_i = 1'b1;
            exp_q.push_back(cyc + 1);
            exp_evt++;
        end
        @(negedge clk); mst_trig_i = 1'b0;
        mst_level_i = 1'b1; tick(2);
        @(negedge clk); mst_trig_i = 1'b1;
        exp_q.push_back(cyc + 1); exp_evt++;
        tick(4);
        mst_trig_i = 1'b0; tick(3);
        mst_sel_i = 1'b0;
        @(negedge clk); mst_trig_i = 1'b1;
        tick(2);
        mst_trig_i = 1'b0; tick(3);
        chk("R3", "evt master modes", 64'(evt_cnt_o), 64'(exp_evt));

        // R5: holdoff of 5 cycles
        holdoff_len_i = 8'd5;
        @(negedge clk); start_i = 1'b1; force_i = 1'b1; k = cyc;
        @(negedge clk); start_i = 1'b0; force_i = 1'b0;
        while (cyc < k + 5) @(negedge clk);
        force_i = 1'b1;
        @(negedge clk);
        exp_q.push_back(cyc + 1); exp_evt++;
        @(negedge clk); force_i = 1'b0;
        // R5: holdoff of 0 blocks only the start cycle
        holdoff_len_i = 8'd0;
        @(negedge clk); start_i = 1'b1; force_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        exp_q.push_back(cyc + 1); exp_evt++;
        @(negedge clk); force_i = 1'b0;
        tick(2);
        chk("R5", "evt after holdoff", 64'(evt_cnt_o), 64'(exp_evt));

        // R7 and R9: trigger while busy, deadtime of 10
        @(negedge clk); busy_i = 1'b1; k = cyc;
        tick(2);
        @(negedge clk); force_i = 1'b1; exp_evt++; exp_lost++;
        @(negedge clk); force_i = 1'b0;
        while (cyc < k + 10) @(negedge clk);
        busy_i = 1'b0;
        tick(2);
        chk("R7", "lost count", 64'(lost_cnt_o), 64'(exp_lost));
        chk("R7", "evt incl lost", 64'(evt_cnt_o), 64'(exp_evt));
        chk("R9", "deadtime", 64'(dead_o), 64'(10));
        force_pulse(1'b1);
        tick(2);

        // R6: generator rates over 64-cycle windows
        sb_on = 1'b0;
        gen_rate_i = 32'd0; tick(8);
        window(64, n, d);
        chk("R6", "rate 0 triggers", 64'(n), 64'(0));
        gen_rate_i = 32'h8000_0000; tick(8);
        window(64, n, d);
        chk("R6", "rate 2^31 triggers", 64'(n), 64'(32));
        chk("R8", "rate 2^31 evt delta", 64'(d), 64'(32));
        gen_rate_i = 32'h4000_0000; tick(8);
        window(64, n, d);
        chk("R6", "rate 2^30 triggers", 64'(n), 64'(16));
        // R3: generator ignored under master selection
        gen_rate_i = 32'h8000_0000;
        mst_sel_i = 1'b1; tick(4);
        window(64, n, d);
        chk("R3", "generator under master select", 64'(n), 64'(0));
        mst_sel_i = 1'b0; tick(4);
        // R8: force coincident with generator merges
        force_i = 1'b1; tick(2);
        window(64, n, d);
        force_i = 1'b0;
        chk("R8", "merged triggers", 64'(n), 64'(64));
        chk("R8", "merged evt delta", 64'(d), 64'(64));
        gen_rate_i = 32'd0;
        tick(6);
        sb_on = 1'b1;

        // R10: deadtime saturates
        @(negedge clk); busy_i = 1'b1;
        tick(70000);
        busy_i = 1'b0;
        tick(3);
        chk("R10", "deadtime saturation", 64'(dead_o), 64'(16'hFFFF));

        tick(4);
        chk("R11", "pending expected triggers", 64'(exp_q.size()), 64'(0));
        finish_run();
    end
endmodule